// File: doc/BRIEF.md
# Dual-Mode 8-bit PWM Timer

This block is an 8-bit timer that drives one waveform pin. A prescaler turns the system clock into step pulses. The counter advances only on those pulses. It runs in one of two modes. In single-slope mode the counter climbs to its ceiling and wraps to zero. In dual-slope mode it climbs to the ceiling and then falls back to zero, which keeps the pulse centred for motor-style loads. The ceiling is either the fixed value 0xFF or the value in compare register A.

The host writes two compare registers, A and B. These writes land in holding copies. The copies become active only at a fixed point in the count cycle, so a period is never built from a mix of old and new values. The output can be off, toggling, non-inverting PWM or inverting PWM. Two sticky flags report a counter turnover and a compare match. Each flag is cleared by pulsing its clear pin with a one.

No data stream passes through the block, so every pin is a plain control or status line. There is no valid/ready handshake and there are no back-pressure rules. A register write is accepted on every clock in which `wr_en` is high.

Top module: `pwm_timer8`

## Requirements
- R1: While `rst` is high on a clock edge, the block clears all of its state. After that edge `count` is 0, `wave` is 0, both flags are 0, and both holding and both active compare values are 0.
- R2: `presc_sel` sets the step rate. Codes 1 to 7 give one counter step every 1, 8, 32, 64, 128, 256 and 1024 clocks. Code 0 stops the counter, so `count` holds its value.
- R3: In single-slope mode (`dual_slope`=0) the counter steps 0, 1, ... up to TOP and then back to 0. TOP is 255 when `top_sel`=0. TOP is the active A value when `top_sel`=1.
- R4: Single-slope PWM. With `out_mode`=2, `wave` is high while the count is at or below the active B value. That gives B+1 high steps out of every TOP+1. B=0 gives a high spike of one step. B at or above TOP gives a constant high. `out_mode`=3 gives the complement.
- R5: With `out_mode`=1, `wave` inverts on every step taken while the count equals the active A value. With `top_sel`=1, A=0 and `presc_sel`=1, it inverts on every clock.
- R6: In dual-slope mode the count runs 0 up to TOP and back down to 0, then repeats, for a period of 2×TOP steps. The count shows TOP for exactly one step. TOP is chosen by `top_sel` as in R3.
- R7: Dual-slope PWM. With `out_mode`=2, `wave` falls where the rising count passes B and rises where the falling count returns to B. That gives 2×B high steps per period. B=0 gives a constant low and B at or above TOP gives a constant high. `out_mode`=3 gives the complement.
- R8: A write with `wr_en`=1 stores `wr_data` in the A holding copy when `wr_sel`=0, and in the B holding copy when `wr_sel`=1. Both holding copies become active on the step that leaves TOP, in either mode. Until that step the output keeps following the old values.
- R9: `ovf_flag` is set by the step that leaves TOP in single-slope mode, and by the step that leaves 0 on the way down in dual-slope mode. A one on `clr_ovf` clears it. If a set and a clear arrive in the same cycle, the set wins.
- R10: `cmp_flag` is set by every step taken while the count equals the selected compare value. That value is A when `out_mode`=1 and B otherwise. A one on `clr_cmp` clears it. If a set and a clear arrive in the same cycle, the set wins.
- R11: With `out_mode`=0 the waveform is disconnected and `wave` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| presc_sel | input | 3 | Step rate code (0 = stopped, 1..7 = divide by 1, 8, 32, 64, 128, 256, 1024) |
| dual_slope | input | 1 | 0 = single-slope, 1 = dual-slope |
| top_sel | input | 1 | 0 = ceiling 255, 1 = ceiling from active A |
| out_mode | input | 2 | 0 off, 1 toggle, 2 PWM, 3 inverted PWM |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 1 | 0 = register A, 1 = register B |
| wr_data | input | 8 | Value to write |
| clr_ovf | input | 1 | Write-one-to-clear for the turnover flag |
| clr_cmp | input | 1 | Write-one-to-clear for the match flag |
| wave | output | 1 | Waveform pin |
| count | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky turnover flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
Each fault shows up at the ports within one count period. A wrong direction bit or an off-by-one at the ceiling changes how many high clocks the pin gives in one period, and it shows as a wrong neighbour of the peak count. A compare copy loaded too early changes the pin level in the very period in which the host wrote. A prescaler with a wrong divide value shows as a wrong gap between count changes. A flag raised on the wrong step is caught with the clear held high, because the flag is then visible only in the clock right after its set event, and the count in that clock must equal the value that follows the event.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_PWM    = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_e;

  // log2 of the clock divide ratio for each rate code
  function automatic int unsigned rate_shift(input logic [2:0] code);
    case (code)
      3'd1:    return 0;
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int DIV_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rate,
  output logic       step
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit = DIV_W'((32'd1 << pwm_pkg::rate_shift(rate)) - 32'd1);
    step  = (rate != 3'd0) && (div_q >= limit);
  end

  always_ff @(posedge clk) begin
    if (rst || rate == 3'd0) div_q <= '0;
    else if (step)           div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end

  // R2
  step_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && limit != '0) |=> (!step || !$stable(rate)));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         dual,
  input  logic         top_sel,
  input  logic [W-1:0] hold_a,
  input  logic [W-1:0] hold_b,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic [W-1:0] act_a,
  output logic [W-1:0] act_b,
  output logic [W-1:0] ceil,
  output logic         turn_evt
);
  logic [W-1:0] cnt_q;
  logic         down_q;
  logic [W-1:0] a_q, b_q;
  logic         at_ceil;

  always_comb begin
    ceil    = top_sel ? a_q : {W{1'b1}};
    at_ceil = (cnt_q >= ceil);
    turn_evt = step && (dual ? (down_q && cnt_q == '0) : at_ceil);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (step) begin
      if (!dual) begin
        down_q <= 1'b0;
        if (at_ceil) begin
          cnt_q <= '0;
          a_q   <= hold_a;
          b_q   <= hold_b;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (!down_q) begin
        if (at_ceil) begin
          down_q <= 1'b1;
          cnt_q  <= (ceil == '0) ? '0 : ceil - 1'b1;
          a_q    <= hold_a;
          b_q    <= hold_b;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          down_q <= 1'b0;
          cnt_q  <= (ceil == '0) ? '0 : W'(1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt   = cnt_q;
  assign down  = down_q;
  assign act_a = a_q;
  assign act_b = b_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt_q));
  // R3
  single_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !dual && at_ceil) |=> (cnt_q == '0));
  // R6
  fall_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && dual && down_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               dual,
  input  pwm_pkg::out_mode_e mode,
  input  logic [W-1:0]       cnt,
  input  logic               down,
  input  logic [W-1:0]       act_a,
  input  logic [W-1:0]       act_b,
  input  logic [W-1:0]       ceil,
  output logic               wave,
  output logic               hit
);
  import pwm_pkg::*;

  logic [W-1:0] ref_v;
  logic         lvl;
  logic         wave_q;

  always_comb begin
    ref_v = (mode == OUT_TOGGLE) ? act_a : act_b;
    hit   = step && (cnt == ref_v);
    if (!dual)              lvl = (cnt <= ref_v);
    else if (ref_v == '0)   lvl = 1'b0;
    else if (ref_v >= ceil) lvl = 1'b1;
    else                    lvl = down ? (cnt <= ref_v) : (cnt < ref_v);
  end

  always_ff @(posedge clk) begin
    if (rst) wave_q <= 1'b0;
    else begin
      case (mode)
        OUT_OFF:    wave_q <= 1'b0;
        OUT_TOGGLE: wave_q <= hit ? ~wave_q : wave_q;
        OUT_PWM:    wave_q <= lvl;
        default:    wave_q <= ~lvl;
      endcase
    end
  end

  assign wave = wave_q;

  // R11
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OUT_OFF) |=> !wave_q);
  // R5
  toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OUT_TOGGLE && !hit) |=> (wave_q == $past(wave_q)));
  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OUT_TOGGLE && hit) |=> (wave_q != $past(wave_q)));

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8 #(
  parameter int W     = 8,
  parameter int DIV_W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   presc_sel,
  input  logic         dual_slope,
  input  logic         top_sel,
  input  logic [1:0]   out_mode,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         clr_ovf,
  input  logic         clr_cmp,
  output logic         wave,
  output logic [W-1:0] count,
  output logic         ovf_flag,
  output logic         cmp_flag
);
  logic         step;
  logic [W-1:0] hold_a, hold_b;
  logic [W-1:0] act_a, act_b, ceil;
  logic         down, turn_evt, hit;
  logic         ovf_q, cmp_q;

  pwm_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk (clk), .rst (rst), .rate (presc_sel), .step (step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_a <= '0;
      hold_b <= '0;
    end else if (wr_en) begin
      if (wr_sel) hold_b <= wr_data;
      else        hold_a <= wr_data;
    end
  end

  pwm_counter #(.W(W)) u_cnt (
    .clk (clk), .rst (rst), .step (step), .dual (dual_slope),
    .top_sel (top_sel), .hold_a (hold_a), .hold_b (hold_b),
    .cnt (count), .down (down), .act_a (act_a), .act_b (act_b),
    .ceil (ceil), .turn_evt (turn_evt)
  );

  pwm_wave #(.W(W)) u_wave (
    .clk (clk), .rst (rst), .step (step), .dual (dual_slope),
    .mode (pwm_pkg::out_mode_e'(out_mode)), .cnt (count), .down (down),
    .act_a (act_a), .act_b (act_b), .ceil (ceil),
    .wave (wave), .hit (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      if (turn_evt)     ovf_q <= 1'b1;
      else if (clr_ovf) ovf_q <= 1'b0;
      if (hit)          cmp_q <= 1'b1;
      else if (clr_cmp) cmp_q <= 1'b0;
    end
  end

  assign ovf_flag = ovf_q;
  assign cmp_flag = cmp_q;

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    turn_evt |=> ovf_flag);
  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ovf && !turn_evt) |=> !ovf_flag);
  // R10
  cmp_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> cmp_flag);
  // R10
  cmp_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_cmp && !hit) |=> !cmp_flag);

endmodule

// File: tb/pwm_timer8_tb.sv
module pwm_timer8_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] presc_sel = 3'd0;
  logic       dual_slope = 1'b0;
  logic       top_sel = 1'b0;
  logic [1:0] out_mode = 2'd0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       clr_ovf = 1'b0;
  logic       clr_cmp = 1'b0;
  logic       wave;
  logic [7:0] count;
  logic       ovf_flag, cmp_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pwm_timer8 u_dut (
    .clk (clk), .rst (rst), .presc_sel (presc_sel), .dual_slope (dual_slope),
    .top_sel (top_sel), .out_mode (out_mode), .wr_en (wr_en), .wr_sel (wr_sel),
    .wr_data (wr_data), .clr_ovf (clr_ovf), .clr_cmp (clr_cmp),
    .wave (wave), .count (count), .ovf_flag (ovf_flag), .cmp_flag (cmp_flag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic restart(input logic [2:0] sel, input logic dual, input logic ts,
                         input logic [1:0] om);
    rst = 1'b1; presc_sel = sel; dual_slope = dual; top_sel = ts; out_mode = om;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic window(input int n, output int highs, output int maxc);
    highs = 0; maxc = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (wave) highs++;
      if (int'(count) > maxc) maxc = int'(count);
    end
  endtask

  task automatic t_reset();
    restart(3'd1, 1'b0, 1'b0, 2'd2);
    tick(40);
    rst = 1'b1;
    tick(1);
    chk(count == 8'd0 && wave == 1'b0, "R1 count/wave in reset", int'(count), 0);
    chk(!ovf_flag && !cmp_flag, "R1 flags in reset", int'({ovf_flag, cmp_flag}), 0);
    rst = 1'b0;
  endtask

  task automatic t_single();
    int h, m;
    bit wrap_ok;
    restart(3'd1, 1'b0, 1'b0, 2'd2);
    wr(1'b1, 8'd64);
    tick(300);
    window(256, h, m);
    chk(h == 65, "R4 non-inverting B=64", h, 65);
    chk(m == 255, "R3 ceiling 255", m, 255);
    wrap_ok = 1'b0;
    for (int i = 0; i < 260; i++) begin
      tick(1);
      if (count == 8'd255) begin
        tick(1);
        wrap_ok = (count == 8'd0);
        break;
      end
    end
    chk(wrap_ok, "R3 wrap 255 to 0", int'(count), 0);
    out_mode = 2'd3;
    tick(4);
    window(256, h, m);
    chk(h == 191, "R4 inverting B=64", h, 191);
    out_mode = 2'd2;
    wr(1'b1, 8'd0);
    tick(300);
    window(256, h, m);
    chk(h == 1, "R4 B=0 spike", h, 1);
    wr(1'b1, 8'd255);
    tick(300);
    window(256, h, m);
    chk(h == 256, "R4 B=MAX constant", h, 256);
  endtask

  task automatic t_top_a();
    int h, m;
    restart(3'd1, 1'b0, 1'b1, 2'd2);
    wr(1'b0, 8'd99);
    wr(1'b1, 8'd49);
    tick(250);
    window(100, h, m);
    chk(h == 50, "R4 duty with ceiling from A", h, 50);
    chk(m == 99, "R3 ceiling from A", m, 99);
  endtask

  task automatic t_toggle();
    int flips;
    logic prev;
    restart(3'd1, 1'b0, 1'b1, 2'd1);
    tick(10);
    flips = 0;
    prev = wave;
    for (int i = 0; i < 16; i++) begin
      tick(1);
      if (wave != prev) flips++;
      prev = wave;
    end
    chk(flips == 16, "R5 A=0 flips every clock", flips, 16);
    wr(1'b0, 8'd3);
    tick(20);
    flips = 0;
    prev = wave;
    for (int i = 0; i < 16; i++) begin
      tick(1);
      if (wave != prev) flips++;
      prev = wave;
    end
    chk(flips == 4, "R5 A=3 flips every 4 clocks", flips, 4);
  endtask

  task automatic gap(output int n);
    logic [7:0] c0;
    c0 = count;
    while (count == c0) tick(1);
    c0 = count;
    n = 0;
    while (count == c0 && n < 3000) begin
      tick(1);
      n++;
    end
  endtask

  task automatic t_presc();
    int n;
    logic [7:0] c0;
    restart(3'd2, 1'b0, 1'b0, 2'd2);
    gap(n);
    chk(n == 8, "R2 divide by 8", n, 8);
    presc_sel = 3'd7;
    tick(1100);
    gap(n);
    chk(n == 1024, "R2 divide by 1024", n, 1024);
    presc_sel = 3'd0;
    tick(2);
    c0 = count;
    tick(100);
    chk(count == c0, "R2 code 0 stops counter", int'(count), int'(c0));
  endtask

  task automatic t_dual();
    int h, m;
    bit peak_ok;
    logic [7:0] prev;
    restart(3'd1, 1'b1, 1'b0, 2'd2);
    wr(1'b1, 8'd64);
    tick(600);
    window(510, h, m);
    chk(h == 128, "R7 non-inverting B=64", h, 128);
    peak_ok = 1'b0;
    prev = count;
    for (int i = 0; i < 520; i++) begin
      tick(1);
      if (count == 8'd255) begin
        tick(1);
        peak_ok = (prev == 8'd254) && (count == 8'd254);
        break;
      end
      prev = count;
    end
    chk(peak_ok, "R6 peak shown one step between 254s", int'(count), 254);
    out_mode = 2'd3;
    tick(4);
    window(510, h, m);
    chk(h == 382, "R7 inverting B=64", h, 382);
    out_mode = 2'd2;
    wr(1'b1, 8'd0);
    tick(600);
    window(510, h, m);
    chk(h == 0, "R7 B=0 constant low", h, 0);
    wr(1'b1, 8'd255);
    tick(600);
    window(510, h, m);
    chk(h == 510, "R7 B=MAX constant high", h, 510);
    restart(3'd1, 1'b1, 1'b1, 2'd2);
    wr(1'b0, 8'd100);
    wr(1'b1, 8'd50);
    tick(500);
    window(200, h, m);
    chk(h == 100, "R7 duty with ceiling from A", h, 100);
    chk(m == 100, "R6 ceiling from A", m, 100);
  endtask

  task automatic t_dbuf();
    int h, m;
    restart(3'd1, 1'b0, 1'b0, 2'd2);
    wr(1'b1, 8'd64);
    tick(300);
    while (count != 8'd100) tick(1);
    wr(1'b1, 8'd200);
    while (count != 8'd150) tick(1);
    tick(1);
    chk(wave == 1'b0, "R8 old B kept until wrap", int'(wave), 0);
    while (count != 8'd0) tick(1);
    tick(5);
    window(256, h, m);
    chk(h == 201, "R8 new B after wrap", h, 201);
  endtask

  task automatic t_flags();
    bit ok_pos;
    int seen;
    restart(3'd1, 1'b0, 1'b1, 2'd2);
    wr(1'b0, 8'd9);
    wr(1'b1, 8'd4);
    tick(30);
    chk(ovf_flag && cmp_flag, "R9 R10 flags set and sticky",
        int'({ovf_flag, cmp_flag}), 3);
    clr_ovf = 1'b1; clr_cmp = 1'b1;
    ok_pos = 1'b1; seen = 0;
    for (int i = 0; i < 60; i++) begin
      tick(1);
      if (ovf_flag) begin seen++; if (count != 8'd0) ok_pos = 1'b0; end
      if (cmp_flag && count != 8'd5) ok_pos = 1'b0;
    end
    chk(ok_pos && seen == 6, "R9 single-slope flag after leaving TOP", seen, 6);
    clr_ovf = 1'b0; clr_cmp = 1'b0;
    restart(3'd1, 1'b1, 1'b1, 2'd2);
    wr(1'b0, 8'd9);
    wr(1'b1, 8'd4);
    tick(40);
    clr_ovf = 1'b1; clr_cmp = 1'b1;
    ok_pos = 1'b1; seen = 0;
    for (int i = 0; i < 72; i++) begin
      tick(1);
      if (ovf_flag) begin seen++; if (count != 8'd1) ok_pos = 1'b0; end
      if (cmp_flag && count != 8'd5 && count != 8'd3) ok_pos = 1'b0;
    end
    chk(ok_pos && seen == 4, "R9 R10 dual-slope flag positions", seen, 4);
    clr_ovf = 1'b0; clr_cmp = 1'b0;
    restart(3'd1, 1'b0, 1'b1, 2'd2);
    tick(5);
    clr_ovf = 1'b1;
    tick(3);
    chk(ovf_flag == 1'b1, "R9 set wins over clear", int'(ovf_flag), 1);
    clr_ovf = 1'b0;
  endtask

  task automatic t_off();
    int h, m;
    restart(3'd1, 1'b0, 1'b0, 2'd0);
    wr(1'b1, 8'd128);
    tick(300);
    window(256, h, m);
    chk(h == 0, "R11 disconnected output low", h, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired, all requirements actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(2);
    t_reset();
    t_single();
    t_top_a();
    t_toggle();
    t_presc();
    t_dual();
    t_dbuf();
    t_flags();
    t_off();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule